// File: doc/BRIEF.md
# Programmable Logic Output Cell

This block models a single output cell of a sum-of-products programmable logic device. Eight product-term inputs and one dedicated control product term come in from an external AND array. The cell ORs them into a combinatorial output, or feeds them into a flip-flop whose type is chosen by configuration: data, toggle, J-K or set-reset. It drives an output value and an output enable toward the pin, and returns a feedback bit to the array.

Everything runs on one system clock. The cell's own clock is either the pin clock or the control product term. That selected signal is sampled on the system clock, and only a low-to-high transition loads the flip-flop. Which clock source is chosen also decides whether output enable follows the control term or stays on. For the J-K and set-reset types, a programmable count N splits the eight terms between the two flip-flop inputs. The configuration word is sampled on system clock edges while reset is asserted and is frozen once reset is released.

Top module: `pld_cell`

## Requirements
- R1: With cfg bit 0 = 0 (combinatorial), out_o equals the OR of all eight pt_i bits, XORed with the output-invert bit cfg[4].
- R2: In combinatorial mode, or in registered mode with pin clock (cfg[3] = 0), oe_o equals ctl_pt_i. In registered mode with the product-term clock (cfg[3] = 1), oe_o is 1.
- R3: Type D (cfg[2:1] = 0): on a clock edge the register loads the OR of all terms XORed with the input-invert bit cfg[5].
- R4: Type T (cfg[2:1] = 1): on a clock edge the register toggles when the OR of all terms XOR cfg[5] is 1, and otherwise holds.
- R5: Type J-K (cfg[2:1] = 2): on a clock edge, J/K = 00 holds, 01 clears, 10 sets and 11 toggles.
- R6: The split count N = cfg[11:8] (values above 8 read as 8) routes terms pt_i[N-1:0] to J/S and pt_i[7:N] to K/R. J is inverted by cfg[5] and K by cfg[6]. N = 0 forces J/S low, and N = 8 forces K/R low, whatever the invert bits.
- R7: Type S-R (cfg[2:1] = 3) uses the same split. S sets, R clears, and S = R = 1 holds; sr_bad_o is high while the cell is registered in S-R mode with S and R both 1.
- R8: The register changes only on a system-clock edge where the selected clock (pin_clk_i when cfg[3] = 0, ctl_pt_i when cfg[3] = 1) is 1 and was 0 at the previous edge. A clock held high or the unselected clock has no effect.
- R9: fb_o equals pin_i when cfg[7] = 1 in combinatorial, D or T mode. Otherwise fb_o is the register's true state in registered mode, or the uninverted OR of the terms in combinatorial mode. In J-K and S-R modes fb_o is always the register state.
- R10: cfg_i is sampled only on system-clock edges while rst_ni is low. Changes after release have no effect.
- R11: Reset clears the register to 0 and clears the stored previous clock level, so a selected clock that is high at release causes a load on the first edge.
- R12: In registered mode out_o is the register state XORed with cfg[4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low; configuration loads while low |
| cfg_i | input | 12 | Configuration word |
| pt_i | input | 8 | Product terms from the array |
| ctl_pt_i | input | 1 | Dedicated clock / output-enable product term |
| pin_clk_i | input | 1 | Pin clock |
| pin_i | input | 1 | Pin level read back for feedback |
| out_o | output | 1 | Output value |
| oe_o | output | 1 | Output enable |
| fb_o | output | 1 | Feedback to the array |
| sr_bad_o | output | 1 | S and R both active in S-R mode |

## Verification
Several properties are checked on every cycle: the combinatorial output function, the two output-enable rules, the freeze of the output when there is no edge on the selected clock, the data and toggle load values, the hold when S and R are both high, register feedback in J-K and S-R modes, and the frozen configuration. The bench scenarios are needed for the full J-K truth table, for the forced-low inputs at split counts 0 and 8, and for pin feedback. They are also needed to show that configuration changes after reset are ignored and that a clock held high through reset loads on the first edge.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;
  typedef enum logic [1:0] {FF_D = 2'd0, FF_T = 2'd1, FF_JK = 2'd2, FF_SR = 2'd3} ff_kind_e;

  localparam int CFG_REG_EN   = 0;
  localparam int CFG_KIND_LSB = 1;
  localparam int CFG_CLK_SRC  = 3;
  localparam int CFG_OUT_INV  = 4;
  localparam int CFG_J_INV    = 5;
  localparam int CFG_K_INV    = 6;
  localparam int CFG_FB_PIN   = 7;
  localparam int CFG_FIXED_W  = 8;
endpackage

// File: rtl/pld_term_split.sv
module pld_term_split #(
  parameter int NT = 8,
  parameter int SW = 4
) (
  input  logic [NT-1:0] pt_i,
  input  logic [SW-1:0] split_i,
  input  logic          j_inv_i,
  input  logic          k_inv_i,
  output logic          sum_raw_o,
  output logic          sum_pol_o,
  output logic          j_o,
  output logic          k_o
);
  localparam logic [SW-1:0] NT_W = SW'(NT);

  logic [SW-1:0] n_eff;
  logic [NT-1:0] j_mask;

  assign n_eff = (split_i > NT_W) ? NT_W : split_i;

  for (genvar i = 0; i < NT; i++) begin : g_mask
    assign j_mask[i] = (SW'(i) < n_eff);
  end

  assign sum_raw_o = |pt_i;
  assign sum_pol_o = sum_raw_o ^ j_inv_i;

  // empty side of the split is forced low, ignoring polarity
  assign j_o = (n_eff == '0)   ? 1'b0 : ((|(pt_i & j_mask))  ^ j_inv_i);
  assign k_o = (n_eff == NT_W) ? 1'b0 : ((|(pt_i & ~j_mask)) ^ k_inv_i);
endmodule

// File: rtl/pld_clk_edge.sv
module pld_clk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_src_i,
  input  logic pin_clk_i,
  input  logic ctl_pt_i,
  output logic rise_o
);
  logic sel, prev_q;

  assign sel = clk_src_i ? ctl_pt_i : pin_clk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sel;
  end

  assign rise_o = sel & ~prev_q;
endmodule

// File: rtl/pld_ff.sv
module pld_ff
  import pld_cell_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rise_i,
  input  ff_kind_e kind_i,
  input  logic     d_i,
  input  logic     j_i,
  input  logic     k_i,
  output logic     q_o,
  output logic     both_o
);
  logic q_q, nxt;

  always_comb begin
    nxt = q_q;
    unique case (kind_i)
      FF_D:  nxt = d_i;
      FF_T:  nxt = q_q ^ d_i;
      FF_JK: begin
        unique case ({j_i, k_i})
          2'b00: nxt = q_q;
          2'b01: nxt = 1'b0;
          2'b10: nxt = 1'b1;
          default: nxt = ~q_q;
        endcase
      end
      default: begin
        unique case ({j_i, k_i})
          2'b01: nxt = 1'b0;
          2'b10: nxt = 1'b1;
          default: nxt = q_q;  // 11 is invalid, treated as hold
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (rise_i) q_q <= nxt;
  end

  assign q_o    = q_q;
  assign both_o = (kind_i == FF_SR) & j_i & k_i;
endmodule

// File: rtl/pld_cell.sv
module pld_cell
  import pld_cell_pkg::*;
#(
  parameter int NUM_TERMS = 8,
  localparam int SPLIT_W = $clog2(NUM_TERMS + 1),
  localparam int CFG_W   = CFG_FIXED_W + SPLIT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CFG_W-1:0]     cfg_i,
  input  logic [NUM_TERMS-1:0] pt_i,
  input  logic                 ctl_pt_i,
  input  logic                 pin_clk_i,
  input  logic                 pin_i,
  output logic                 out_o,
  output logic                 oe_o,
  output logic                 fb_o,
  output logic                 sr_bad_o
);
  logic [CFG_W-1:0] cfg_q;

  // configuration loads only while held in reset
  always_ff @(posedge clk_i) begin
    if (!rst_ni) cfg_q <= cfg_i;
  end

  logic     reg_en, clk_src, out_inv, fb_pin;
  ff_kind_e kind;

  assign reg_en  = cfg_q[CFG_REG_EN];
  assign clk_src = cfg_q[CFG_CLK_SRC];
  assign out_inv = cfg_q[CFG_OUT_INV];
  assign fb_pin  = cfg_q[CFG_FB_PIN];
  assign kind    = ff_kind_e'(cfg_q[CFG_KIND_LSB +: 2]);

  logic sum_raw, sum_pol, j_in, k_in, rise, q, both;

  pld_term_split #(.NT(NUM_TERMS), .SW(SPLIT_W)) u_split (
    .pt_i      (pt_i),
    .split_i   (cfg_q[CFG_FIXED_W +: SPLIT_W]),
    .j_inv_i   (cfg_q[CFG_J_INV]),
    .k_inv_i   (cfg_q[CFG_K_INV]),
    .sum_raw_o (sum_raw),
    .sum_pol_o (sum_pol),
    .j_o       (j_in),
    .k_o       (k_in)
  );

  pld_clk_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_src_i (clk_src),
    .pin_clk_i (pin_clk_i),
    .ctl_pt_i  (ctl_pt_i),
    .rise_o    (rise)
  );

  pld_ff u_ff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .kind_i (kind),
    .d_i    (sum_pol),
    .j_i    (j_in),
    .k_i    (k_in),
    .q_o    (q),
    .both_o (both)
  );

  logic pin_fb_ok;
  assign pin_fb_ok = fb_pin & (~reg_en | (kind == FF_D) | (kind == FF_T));

  always_comb begin
    if (reg_en) begin
      out_o = q ^ out_inv;
      oe_o  = clk_src ? 1'b1 : ctl_pt_i;
      fb_o  = pin_fb_ok ? pin_i : q;
    end else begin
      out_o = sum_raw ^ out_inv;
      oe_o  = ctl_pt_i;
      fb_o  = pin_fb_ok ? pin_i : sum_raw;
    end
  end

  assign sr_bad_o = reg_en & both;
endmodule

// File: rtl/pld_cell_chk.sv
module pld_cell_chk
  import pld_cell_pkg::*;
#(
  parameter int NUM_TERMS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [11:0]          cfg_q,
  input logic                 reg_en,
  input logic [1:0]           kind_b,
  input logic                 clk_src,
  input logic                 out_inv,
  input logic                 j_inv,
  input logic [NUM_TERMS-1:0] pt_i,
  input logic                 ctl_pt_i,
  input logic                 pin_clk_i,
  input logic                 out_o,
  input logic                 oe_o,
  input logic                 fb_o,
  input logic                 sr_bad_o
);
  logic sel_c, prev_c, edge_c;
  assign sel_c  = clk_src ? ctl_pt_i : pin_clk_i;
  assign edge_c = sel_c & ~prev_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_c <= 1'b0;
    else         prev_c <= sel_c;
  end

  assert_comb_out_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_en |-> out_o == ((|pt_i) ^ out_inv));

  assert_oe_forced_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en && clk_src) |-> oe_o);

  assert_oe_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_en || !clk_src) |-> oe_o == ctl_pt_i);

  assert_d_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en && kind_b == FF_D && edge_c) |=> out_o == $past((|pt_i) ^ j_inv ^ out_inv));

  assert_t_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en && kind_b == FF_T && edge_c) |=> out_o == $past(out_o ^ (|pt_i) ^ j_inv));

  assert_sr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_bad_o |=> $stable(out_o));

  assert_sr_flag_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_bad_o |-> (reg_en && kind_b == FF_SR));

  assert_no_edge_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en && !edge_c) |=> $stable(out_o));

  assert_q_feedback_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en && (kind_b == FF_JK || kind_b == FF_SR)) |-> fb_o == (out_o ^ out_inv));

  assert_cfg_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(cfg_q));
endmodule

bind pld_cell pld_cell_chk #(.NUM_TERMS(NUM_TERMS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_q     (cfg_q),
  .reg_en    (cfg_q[0]),
  .kind_b    (cfg_q[2:1]),
  .clk_src   (cfg_q[3]),
  .out_inv   (cfg_q[4]),
  .j_inv     (cfg_q[5]),
  .pt_i      (pt_i),
  .ctl_pt_i  (ctl_pt_i),
  .pin_clk_i (pin_clk_i),
  .out_o     (out_o),
  .oe_o      (oe_o),
  .fb_o      (fb_o),
  .sr_bad_o  (sr_bad_o)
);

// File: tb/pld_cell_test.sv
module pld_cell_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg = '0;
  logic [7:0]  pt = '0;
  logic        ctl = 1'b0, pclk = 1'b0, pin = 1'b0;
  logic        out_o, oe_o, fb_o, sr_bad_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pld_cell uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .pt_i(pt), .ctl_pt_i(ctl),
    .pin_clk_i(pclk), .pin_i(pin), .out_o(out_o), .oe_o(oe_o), .fb_o(fb_o),
    .sr_bad_o(sr_bad_o)
  );

  function automatic logic [11:0] mk(bit reg_en, logic [1:0] kind, bit csrc, bit oinv,
                                      bit jinv, bit kinv, bit fbp, logic [3:0] n);
    return {n, fbp, kinv, jinv, oinv, csrc, kind, reg_en};
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic [11:0] c);
    @(negedge clk);
    cfg = c; rst_n = 1'b0; pt = '0; ctl = 1'b0; pclk = 1'b0; pin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pin_pulse(logic [7:0] p);
    pt = p; pclk = 1'b1;
    @(negedge clk);
    pclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic ctl_pulse(logic [7:0] p);
    pt = p; ctl = 1'b1;
    @(negedge clk);
    ctl = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    do_reset(mk(1, 2'd0, 0, 0, 0, 0, 0, 4'd8));
    chk("R11 reset q=0", out_o, 1'b0);
    do_reset(mk(1, 2'd0, 0, 1, 0, 0, 0, 4'd8));
    chk("R12 reset q inverted", out_o, 1'b1);
    pin_pulse(8'h01);
    chk("R12 loaded 1 shows 0", out_o, 1'b0);
  endtask

  task automatic t_comb;
    do_reset(mk(0, 2'd0, 0, 0, 0, 0, 1, 4'd8));
    pt = 8'h00; ctl = 1'b1; pin = 1'b1; #2;
    chk("R1 comb zero", out_o, 1'b0);
    chk("R2 comb oe high", oe_o, 1'b1);
    chk("R9 comb pin fb", fb_o, 1'b1);
    pt = 8'h10; ctl = 1'b0; pin = 1'b0; #2;
    chk("R1 comb one", out_o, 1'b1);
    chk("R2 comb oe low", oe_o, 1'b0);
    chk("R9 comb pin fb low", fb_o, 1'b0);
    do_reset(mk(0, 2'd0, 0, 1, 0, 0, 0, 4'd8));
    pt = 8'h80; #2;
    chk("R1 comb inverted", out_o, 1'b0);
    chk("R9 comb sum fb", fb_o, 1'b1);
  endtask

  task automatic t_dff;
    do_reset(mk(1, 2'd0, 0, 0, 0, 0, 0, 4'd8));
    pt = 8'h01; @(negedge clk);
    chk("R8 no clock no load", out_o, 1'b0);
    pclk = 1'b1; @(negedge clk);
    chk("R3 d load 1", out_o, 1'b1);
    pt = 8'h00; @(negedge clk); @(negedge clk);
    chk("R8 held clock no load", out_o, 1'b1);
    pclk = 1'b0; @(negedge clk);
    ctl = 1'b1; @(negedge clk);
    chk("R8 unselected clock ignored", out_o, 1'b1);
    chk("R2 pin clock oe follows", oe_o, 1'b1);
    ctl = 1'b0; @(negedge clk);
    chk("R2 pin clock oe low", oe_o, 1'b0);
    pin_pulse(8'h00);
    chk("R3 d load 0", out_o, 1'b0);
    do_reset(mk(1, 2'd0, 0, 0, 1, 0, 0, 4'd8));
    pin_pulse(8'h00);
    chk("R3 d inverted input", out_o, 1'b1);
  endtask

  task automatic t_tff;
    do_reset(mk(1, 2'd1, 0, 0, 0, 0, 0, 4'd8));
    pin_pulse(8'h02);
    chk("R4 toggle to 1", out_o, 1'b1);
    pin_pulse(8'h40);
    chk("R4 toggle to 0", out_o, 1'b0);
    pin_pulse(8'h00);
    chk("R4 hold", out_o, 1'b0);
  endtask

  task automatic t_jk;
    do_reset(mk(1, 2'd2, 0, 0, 0, 0, 0, 4'd4));
    pin_pulse(8'h01); chk("R5 jk set", out_o, 1'b1);
    pin_pulse(8'h00); chk("R5 jk hold", out_o, 1'b1);
    pin_pulse(8'h10); chk("R5 jk clear", out_o, 1'b0);
    pin_pulse(8'h11); chk("R5 jk toggle up", out_o, 1'b1);
    pin_pulse(8'h88); chk("R5 jk toggle down", out_o, 1'b0);
    do_reset(mk(1, 2'd2, 0, 0, 0, 1, 0, 4'd4));
    pin_pulse(8'h01); chk("R6 k inverted toggles", out_o, 1'b1);
    pin_pulse(8'h10); chk("R6 k inverted holds", out_o, 1'b1);
  endtask

  task automatic t_split_edges;
    do_reset(mk(1, 2'd2, 0, 0, 1, 0, 0, 4'd0));
    pin_pulse(8'h00); chk("R6 n=0 j forced low", out_o, 1'b0);
    do_reset(mk(1, 2'd2, 0, 0, 0, 1, 0, 4'd8));
    pin_pulse(8'h01); chk("R6 n=8 j sees term", out_o, 1'b1);
    pin_pulse(8'h00); chk("R6 n=8 k forced low", out_o, 1'b1);
    do_reset(mk(1, 2'd2, 0, 0, 0, 0, 0, 4'd15));
    pin_pulse(8'h80); chk("R6 n above 8 clamps", out_o, 1'b1);
  endtask

  task automatic t_sr;
    do_reset(mk(1, 2'd3, 0, 0, 0, 0, 0, 4'd4));
    pin_pulse(8'h01); chk("R7 sr set", out_o, 1'b1);
    chk("R7 flag clear", sr_bad_o, 1'b0);
    pt = 8'h11; #2;
    chk("R7 flag on s=r=1", sr_bad_o, 1'b1);
    pin_pulse(8'h11); chk("R7 s=r=1 holds", out_o, 1'b1);
    pin_pulse(8'h20); chk("R7 sr clear", out_o, 1'b0);
    chk("R7 flag off", sr_bad_o, 1'b0);
    do_reset(mk(1, 2'd0, 0, 0, 0, 0, 0, 4'd4));
    pt = 8'h11; #2;
    chk("R7 no flag in d mode", sr_bad_o, 1'b0);
  endtask

  task automatic t_pt_clock;
    do_reset(mk(1, 2'd0, 1, 0, 0, 0, 0, 4'd8));
    #2; chk("R2 pt clock oe on", oe_o, 1'b1);
    ctl_pulse(8'h01); chk("R8 pt clock loads", out_o, 1'b1);
    chk("R2 pt clock oe still on", oe_o, 1'b1);
    pin_pulse(8'h00); chk("R8 pin clock ignored", out_o, 1'b1);
    ctl_pulse(8'h00); chk("R8 pt clock loads 0", out_o, 1'b0);
  endtask

  task automatic t_feedback;
    do_reset(mk(1, 2'd0, 0, 0, 0, 0, 1, 4'd8));
    pin = 1'b1; #2; chk("R9 d pin fb 1", fb_o, 1'b1);
    pin = 1'b0; #2; chk("R9 d pin fb 0", fb_o, 1'b0);
    do_reset(mk(1, 2'd1, 0, 1, 0, 0, 0, 4'd8));
    pin_pulse(8'h01);
    pin = 1'b0; #2; chk("R9 t q fb", fb_o, 1'b1);
    do_reset(mk(1, 2'd2, 0, 0, 0, 0, 1, 4'd4));
    pin = 1'b1; #2; chk("R9 jk ignores pin fb", fb_o, 1'b0);
  endtask

  task automatic t_cfg_frozen;
    do_reset(mk(1, 2'd0, 0, 0, 0, 0, 0, 4'd8));
    cfg = mk(0, 2'd0, 0, 0, 0, 0, 0, 4'd8);
    pt = 8'h01;
    @(negedge clk); @(negedge clk);
    chk("R10 late cfg ignored", out_o, 1'b0);
  endtask

  task automatic t_clock_through_reset;
    @(negedge clk);
    cfg = mk(1, 2'd0, 0, 0, 0, 0, 0, 4'd8);
    rst_n = 1'b0; pt = 8'h01; pclk = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 held in reset", out_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 first edge loads", out_o, 1'b1);
    pclk = 1'b0; pt = 8'h00;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_comb();
    t_dff();
    t_tff();
    t_jk();
    t_split_edges();
    t_sr();
    t_pt_clock();
    t_feedback();
    t_cfg_frozen();
    t_clock_through_reset();
    finish_run();
  end
endmodule